// File: doc/BRIEF.md
# Non-Restoring Division Step Unit

This unit performs one bit of a non-restoring binary division per clock. It keeps three status bits: a divisor-sign bit (M), a partial-quotient bit (Q) and a carry-style bit (T). The partial remainder itself is not stored in the unit. The caller presents it on `rn_in` and takes the updated value from `rn_out` in the same cycle. A sequencer or software loop keeps that value in its own register between steps.

Each cycle carries one of four operations:
- **Hold** leaves everything alone.
- **Unsigned init** clears the status bits.
- **Signed init** seeds the status bits from the sign bits of the dividend and the divisor.
- **Step** does the work. It shifts the partial remainder left and feeds the current T into the vacated bit. It then adds or subtracts the divisor, with the choice made by whether Q and M agree. Finally it rebuilds Q and T from the sign bit that was shifted out and the carry or borrow of that add or subtract.

Because T is fed back into the low bit on every step, quotient bits accumulate in the low end of the remainder register. For an unsigned 32/16 division the caller does the following:
1. Loads the 16-bit divisor into the upper half of `rm_in`.
2. Issues an unsigned init.
3. Issues sixteen steps.
4. Forms `(rn << 1) | T`. The quotient is then in the low half of that value.

Top module: `divstep_unit`

## Requirements
- R1: After reset, the `q_flag`, `m_flag` and `t_flag` outputs are all 0.
- R2: Operation code 2'b01 (unsigned init) makes Q, M and T all 0 from the next clock edge.
- R3: Operation code 2'b10 (signed init) sets the following from the next edge:
  - Q to `rn_in[W-1]`
  - M to `rm_in[W-1]`
  - T to Q XOR M
- R4: With operation code 2'b11 (step), let S be `{rn_in[W-2:0], T}`. In the same cycle, `rn_out` equals S minus `rm_in` (modulo 2^W) when the current Q equals M. Otherwise it equals S plus `rm_in`.
- R5: After a step, Q equals `rn_in[W-1]` XOR M XOR K. K is the carry out of the addition, or the borrow of the subtraction, performed in R4.
- R6: After a step, M is unchanged, and T is 1 exactly when the new Q equals M.
- R7: Operation code 2'b00 (hold) leaves Q, M and T unchanged. For every operation other than step, `rn_out` equals `rn_in`.
- R8: Take a dividend N and a divisor D below 2^16 with `N >> 16` < D, and apply this sequence:
  - unsigned init
  - sixteen steps with `rm_in` = D << 16, each step feeding back the previous `rn_out`, starting from N
  
  Afterwards, the low 16 bits of `(rn << 1) | T` equal N / D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 2 | Operation: 00 hold, 01 unsigned init, 10 signed init, 11 step |
| rn_in | input | W | Partial remainder / dividend register value |
| rm_in | input | W | Divisor register value |
| rn_out | output | W | Updated partial remainder (combinational) |
| q_flag | output | 1 | Stored Q bit |
| m_flag | output | 1 | Stored M bit |
| t_flag | output | 1 | Stored T bit |

## Verification
Within one step, two separate effects both feed the new Q:
- the sign bit shifted out of the remainder;
- the carry or borrow of the add/subtract.

When both are set they cancel. A directed step provokes this. After an unsigned init, it applies a remainder of 0x8000_0000 and a divisor of 1: the shift drops a 1 into Q, and the subtraction borrows. The expected result is a remainder of all ones, Q = 0 and T = 1. The bench's behavioural model checks every other step on each clock, using 64-bit integer arithmetic rather than the unit's bit-vector add. Full division loops are also checked against the bench's own integer division.

// File: rtl/divstep_pkg.sv
package divstep_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'b00,
    OP_UINIT = 2'b01,
    OP_SINIT = 2'b10,
    OP_STEP  = 2'b11
  } divop_e;

  typedef struct packed {
    logic q;
    logic m;
    logic t;
  } divflags_t;

endpackage

// File: rtl/divstep_alu.sv
module divstep_alu #(
  parameter int W = 32
) (
  input  logic [W-1:0] rn,
  input  logic [W-1:0] rm,
  input  logic         t_in,
  input  logic         do_sub,
  output logic [W-1:0] res,
  output logic         carry_borrow,
  output logic         shifted_out
);

  localparam int WX = W + 1;

  // Shift the remainder left by one, filling the vacated bit with T.
  function automatic logic [W-1:0] shift_in(input logic [W-1:0] v, input logic b);
    return {v[W-2:0], b};
  endfunction

  // Widened add/subtract: the top bit is the carry (add) or the borrow (subtract).
  function automatic logic [WX-1:0] addsub(input logic [W-1:0] a,
                                           input logic [W-1:0] b,
                                           input logic sub);
    logic [WX-1:0] ax, bx;
    ax = {1'b0, a};
    bx = {1'b0, b};
    return sub ? (ax - bx) : (ax + bx);
  endfunction

  logic [W-1:0]  shifted;
  logic [WX-1:0] wide;

  always_comb begin
    shifted      = shift_in(rn, t_in);
    wide         = addsub(shifted, rm, do_sub);
    res          = wide[W-1:0];
    carry_borrow = wide[W];
    shifted_out  = rn[W-1];
  end

endmodule

// File: rtl/divstep_flags.sv
module divstep_flags
  import divstep_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  divop_e op,
  input  logic   rn_msb,
  input  logic   rm_msb,
  input  logic   step_cb,
  output logic   q,
  output logic   m,
  output logic   t,
  output logic   do_sub
);

  divflags_t cur, nxt;

  always_comb begin
    nxt = cur;
    unique case (op)
      OP_UINIT: nxt = '{q: 1'b0, m: 1'b0, t: 1'b0};
      OP_SINIT: nxt = '{q: rn_msb, m: rm_msb, t: rn_msb ^ rm_msb};
      OP_STEP: begin
        nxt.q = rn_msb ^ cur.m ^ step_cb;
        nxt.t = (nxt.q == cur.m);
      end
      default: nxt = cur;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= '0;
    else        cur <= nxt;
  end

  assign q      = cur.q;
  assign m      = cur.m;
  assign t      = cur.t;
  assign do_sub = (cur.q == cur.m);

  // R2
  uinit_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_UINIT) |=> (!q && !m && !t));

  // R3
  sinit_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SINIT) |=> (q == $past(rn_msb) && m == $past(rm_msb) && t == (q ^ m)));

  // R6
  step_t_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_STEP) |=> (t == (q == m)));

  // R6
  step_m_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_STEP) |=> $stable(m));

  // R7
  hold_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_HOLD) |=> ($stable(q) && $stable(m) && $stable(t)));

endmodule

// File: rtl/divstep_unit.sv
module divstep_unit
  import divstep_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] rn_in,
  input  logic [W-1:0] rm_in,
  output logic [W-1:0] rn_out,
  output logic         q_flag,
  output logic         m_flag,
  output logic         t_flag
);

  localparam int MSB = W - 1;

  divop_e       op;
  logic         do_sub;
  logic         step_cb;
  logic         shifted_out;
  logic [W-1:0] step_res;

  assign op = divop_e'(op_i);

  divstep_alu #(.W(W)) i_alu (
    .rn           (rn_in),
    .rm           (rm_in),
    .t_in         (t_flag),
    .do_sub       (do_sub),
    .res          (step_res),
    .carry_borrow (step_cb),
    .shifted_out  (shifted_out)
  );

  divstep_flags i_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (op),
    .rn_msb  (rn_in[MSB]),
    .rm_msb  (rm_in[MSB]),
    .step_cb (step_cb),
    .q       (q_flag),
    .m       (m_flag),
    .t       (t_flag),
    .do_sub  (do_sub)
  );

  assign rn_out = (op == OP_STEP) ? step_res : rn_in;

  // R7
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op != OP_STEP) |-> (rn_out == rn_in));

  // R5
  step_q_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_STEP) |=> (q_flag == ($past(shifted_out) ^ m_flag ^ $past(step_cb))));

endmodule

// File: tb/test_divstep_unit.sv
module test_divstep_unit;

  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    op_i = 2'b00;
  logic [W-1:0]  rn_in = '0;
  logic [W-1:0]  rm_in = '0;
  logic [W-1:0]  rn_out;
  logic          q_flag, m_flag, t_flag;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 0;

  // behavioural model state
  bit mq, mm, mt;
  string tag_q = "R1", tag_mt = "R1";

  always #10 clk = ~clk;

  divstep_unit #(.W(W)) i_divstep_unit (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .rn_in(rn_in), .rm_in(rm_in),
    .rn_out(rn_out), .q_flag(q_flag), .m_flag(m_flag), .t_flag(t_flag)
  );

  task automatic chk(input string req, input longint act, input longint exp, input string what);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_flags();
    chk(tag_q,  q_flag, mq, "Q");
    chk(tag_mt, m_flag, mm, "M");
    chk(tag_mt, t_flag, mt, "T");
  endtask

  // One operation: check flags, drive, check rn_out, advance model.
  task automatic do_op(input bit [1:0] op, input bit [31:0] rn, input bit [31:0] rm,
                       output bit [31:0] result);
    longint sh, r;
    bit k, nq;
    bit [31:0] exp_rn;
    @(negedge clk);
    check_flags();
    op_i = op; rn_in = rn; rm_in = rm;
    #1;
    exp_rn = rn;
    case (op)
      2'b01: begin mq = 0; mm = 0; mt = 0; tag_q = "R2"; tag_mt = "R2"; end
      2'b10: begin mq = rn[31]; mm = rm[31]; mt = mq ^ mm; tag_q = "R3"; tag_mt = "R3"; end
      2'b11: begin
        sh = (longint'(rn) * 2 + longint'(mt)) % 64'h1_0000_0000;
        if (mq == mm) begin r = sh - longint'(rm); k = (r < 0); end
        else          begin r = sh + longint'(rm); k = (r >= 64'h1_0000_0000); end
        exp_rn = r[31:0];
        nq = rn[31] ^ mm ^ k;
        mq = nq; mt = (nq == mm);
        tag_q = "R5"; tag_mt = "R6";
      end
      default: begin tag_q = "R7"; tag_mt = "R7"; end
    endcase
    chk(op == 2'b11 ? "R4" : "R7", rn_out, exp_rn, "rn_out");
    result = rn_out;
  endtask

  task automatic udiv(input bit [31:0] n, input bit [15:0] d);
    bit [31:0] x, fin;
    do_op(2'b01, 32'h0, 32'h0, x);
    x = n;
    for (int i = 0; i < 16; i++) do_op(2'b11, x, {d, 16'h0}, x);
    @(negedge clk);
    check_flags();
    op_i = 2'b00;
    fin = {x[30:0], t_flag};
    chk("R8", fin[15:0], longint'(n / d), "quotient");
  endtask

  task automatic sdiv_run(input bit [31:0] n, input bit [31:0] dsh);
    bit [31:0] x;
    do_op(2'b10, n, dsh, x);
    x = n;
    for (int i = 0; i < 16; i++) do_op(2'b11, x, dsh, x);
  endtask

  initial begin
    bit [31:0] dummy;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", q_flag, 0, "Q at reset");
    chk("R1", m_flag, 0, "M at reset");
    chk("R1", t_flag, 0, "T at reset");
    rst_n = 1'b1;

    // R3 signed init, then R7 hold keeps flags
    do_op(2'b10, 32'h8000_0001, 32'h7FFF_0000, dummy);
    do_op(2'b00, 32'h1234_5678, 32'hFFFF_FFFF, dummy);
    do_op(2'b00, 32'h0, 32'h0, dummy);
    do_op(2'b10, 32'h0000_0001, 32'hFFFB_0000, dummy);
    do_op(2'b10, 32'hF000_0000, 32'h8000_0000, dummy);
    // R2 unsigned init clears
    do_op(2'b01, 32'hAAAA_5555, 32'h5555_AAAA, dummy);

    // R5 shifted-out bit and borrow cancel in one step
    do_op(2'b11, 32'h8000_0000, 32'h0000_0001, dummy);
    chk("R4", dummy, 32'hFFFF_FFFF, "cancel step rn_out");
    @(negedge clk);
    op_i = 2'b00;
    chk("R5", q_flag, 0, "cancel step Q");
    chk("R6", t_flag, 1, "cancel step T");
    mq = 0; mt = 1;

    // R8 unsigned quotients
    udiv(32'd100000, 16'd7);
    udiv(32'h0000_FFFF, 16'd1);
    udiv(32'h1234_5678, 16'hFFFF);
    udiv(32'h0000_0000, 16'd5);
    udiv(32'h0004_FFFF, 16'd5);

    // signed loops against the model (R3..R6)
    sdiv_run(32'hFFFF_FF9C, 32'h0007_0000);
    sdiv_run(32'h0000_0064, 32'hFFF9_0000);
    sdiv_run(32'hFFFF_8000, 32'hFFFF_0000);

    @(negedge clk);
    check_flags();
    done = 1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          n_checks++; n_fails++;
          $display("FAIL watchdog: actual timeout expected completion");
        end
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule